// File: doc/BRIEF.md
# Byte-lane SRAM with sleep control

This block is a clocked, synthesizable model of a 16-bit static memory split into two independently enabled 8-bit lanes. Every control is active low and sampled on the rising clock edge. A write stores the selected lanes at the addressed word. A read returns the selected lanes one cycle later and raises a per-lane drive enable. A bidirectional pad would be driven from the `dout`/`dout_oe` pair, so a cleared drive enable stands for a high-impedance lane. The depth is set by the address-width parameter.

A three-bit mode register controls two power features. The first is a deep-sleep state, entered through a sleep pin. It is inert after reset until the register arms it, and it erases all contents. The second is a retention region that limits which addresses survive while the memory is deselected. Every byte carries a valid flag. A byte that was lost, or that was never written since reset, reads as 8'hFF until it is written again. When the sleep pin is released, accesses stay blocked for a fixed number of cycles.

Top module: `sram_bytelane`

## Requirements
- R1: With `cs_n`=0 and `we_n`=0 at an edge, `din[7:0]` is stored at `addr` when `lb_n`=0, and `din[15:8]` is stored when `ub_n`=0. A lane whose enable is 1 keeps its old byte.
- R2: With `cs_n`=0, `oe_n`=0 and `we_n`=1 at an edge, the output after that edge carries the stored bytes. `dout_oe[0]` is 1 exactly when `lb_n`=0, and `dout_oe[1]` is 1 exactly when `ub_n`=0.
- R3: In any of these cases `dout_oe` is 2'b00 after the edge: `cs_n`=1, both lane enables at 1, `oe_n`=1, `we_n`=0, or reset.
- R4: After reset every byte reads 8'hFF until it is written. A write to one lane makes only that lane valid.
- R5: A cycle with `mode_ld`=1 loads `mode_din`. Bit 0 arms deep sleep. Bits 2:1 select the retained region: 0 keeps all, 1 keeps half, 2 keeps a quarter, 3 keeps an eighth, always counted from address 0. Reset clears the register.
- R6: While the arm bit is 0, `sleep_i` has no effect on accesses or contents.
- R7: With the arm bit at 1, an edge with `sleep_i`=1 enters deep sleep. While asleep, every access is ignored, `dout_oe` stays 0, and all bytes become invalid and read 8'hFF.
- R8: The edge that sees `sleep_i`=0 while asleep leaves sleep. Accesses stay blocked on that edge and on the next WAKE_CYC edges, and work normally on the edge after those.
- R9: On every edge where the memory is deselected (`cs_n`=1, or both lane enables at 1) and the region field is nonzero, bytes at addresses of DEPTH>>field or above become invalid. Bytes below that limit are kept. A field of 0 keeps everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every control is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Low lane (bits 7:0) enable, active low |
| ub_n | input | 1 | High lane (bits 15:8) enable, active low |
| addr | input | AW | Word address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data, registered |
| dout_oe | output | 2 | Per-lane drive enable; 0 means the lane is high-impedance |
| sleep_i | input | 1 | Deep-sleep request, active high |
| mode_ld | input | 1 | Load strobe for the mode register |
| mode_din | input | 3 | Mode value: bit 0 arms sleep, bits 2:1 select the region |

## Verification
A stale or wrong valid flag appears at the next read of the affected byte, as 8'hFF where data was expected or as old data where 8'hFF was expected. Nothing shows until that read, so the bench reads back on both sides of every region limit right after a deselect cycle. A wake counter that is off by one moves by one cycle the first read that raises `dout_oe`. A stuck power state either blocks every access or lets accesses through during sleep, and this is visible on the first read issued while the state is wrong.

// File: rtl/sram_bl_pkg.sv
package sram_bl_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;

    typedef enum logic [1:0] {
        KEEP_ALL     = 2'd0,
        KEEP_HALF    = 2'd1,
        KEEP_QUARTER = 2'd2,
        KEEP_EIGHTH  = 2'd3
    } keep_e;

    // packed so that bit 0 is the arm flag and bits 2:1 the region
    typedef struct packed {
        keep_e keep;
        logic  sleep_arm;
    } mode_t;
endpackage

// File: rtl/sram_bl_mode.sv
module sram_bl_mode
    import sram_bl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ld,
    input  mode_t din,
    output mode_t mode_q
);
    mode_t mode_d;

    always_comb begin
        mode_d = mode_q;
        if (ld) mode_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '{keep: KEEP_ALL, sleep_arm: 1'b0};
        else        mode_q <= mode_d;
    end
endmodule

// File: rtl/sram_bl_power.sv
module sram_bl_power #(
    parameter int WAKE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic arm,
    output logic asleep,
    output logic blocked
);
    localparam int CW = $clog2(WAKE_CYC + 1);

    typedef struct packed {
        logic          asleep;
        logic [CW-1:0] wake;
    } pwr_st_t;

    pwr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.asleep) begin
            if (!sleep_i) begin
                st_d.asleep = 1'b0;
                st_d.wake   = CW'(WAKE_CYC);
            end
        end else if (sleep_i && arm) begin
            st_d.asleep = 1'b1;
            st_d.wake   = '0;
        end else if (st_q.wake != '0) begin
            st_d.wake = st_q.wake - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign asleep  = st_q.asleep;
    assign blocked = st_q.asleep || (st_q.wake != '0);
endmodule

// File: rtl/sram_bl_lane.sv
module sram_bl_lane
    import sram_bl_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [LANE_W-1:0] wdata,
    input  logic              wipe_all,
    input  logic              wipe_hi,
    input  logic [AW:0]       limit,
    output logic [LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DEPTH-1:0]  valid;
        logic [LANE_W-1:0] rdata;
    } lane_st_t;

    logic [LANE_W-1:0] mem [DEPTH];
    lane_st_t st_d, st_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (wipe_all || (wipe_hi && (i >= int'(limit)))) st_d.valid[i] = 1'b0;
        end
        if (wr_en) st_d.valid[addr] = 1'b1;
        if (rd_en) st_d.rdata = st_q.valid[addr] ? mem[addr] : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
endmodule

// File: rtl/sram_bytelane.sv
module sram_bytelane
    import sram_bl_pkg::*;
#(
    parameter int AW       = 10,
    parameter int WAKE_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          lb_n,
    input  logic          ub_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   din,
    output logic [15:0]   dout,
    output logic [1:0]    dout_oe,
    input  logic          sleep_i,
    input  logic          mode_ld,
    input  logic [2:0]    mode_din
);
    localparam logic [AW:0] DEPTH_V = (AW + 1)'(1) << AW;

    typedef struct packed {
        logic [LANES-1:0] oe;
    } top_st_t;

    mode_t            mode_q;
    logic             asleep;
    logic             blocked;
    logic [LANES-1:0] lane_n;
    logic             selected;
    logic             wr_any;
    logic             rd_any;
    logic             wipe_hi;
    logic [AW:0]      limit;
    top_st_t          st_d, st_q;

    sram_bl_mode u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (mode_ld),
        .din    (mode_t'(mode_din)),
        .mode_q (mode_q)
    );

    sram_bl_power #(.WAKE_CYC(WAKE_CYC)) u_power (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_i (sleep_i),
        .arm     (mode_q.sleep_arm),
        .asleep  (asleep),
        .blocked (blocked)
    );

    assign lane_n   = {ub_n, lb_n};
    assign selected = !cs_n && (lane_n != '1);
    assign wr_any   = selected && !we_n && !blocked;
    assign rd_any   = selected && we_n && !oe_n && !blocked;
    assign wipe_hi  = !selected && (mode_q.keep != KEEP_ALL);
    assign limit    = DEPTH_V >> mode_q.keep;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_bl_lane #(.AW(AW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_any && !lane_n[g]),
            .rd_en    (rd_any && !lane_n[g]),
            .addr     (addr),
            .wdata    (din[g*LANE_W +: LANE_W]),
            .wipe_all (asleep),
            .wipe_hi  (wipe_hi),
            .limit    (limit),
            .rdata    (dout[g*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        st_d.oe = rd_any ? ~lane_n : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout_oe = st_q.oe;
endmodule

// File: rtl/sram_bytelane_chk.sv
module sram_bytelane_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       lb_n,
    input logic       ub_n,
    input logic [1:0] dout_oe,
    input logic       arm,
    input logic       asleep,
    input logic       blocked
);
    p_hiz_nonread_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || oe_n || !we_n || (lb_n && ub_n)) |=> (dout_oe == 2'b00));

    p_lane_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && !oe_n && !(lb_n && ub_n) && !blocked)
        |=> (dout_oe == ~$past({ub_n, lb_n})));

    p_unarmed_awake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !asleep) |=> !asleep);

    p_sleep_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |=> (dout_oe == 2'b00));

    p_wake_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> blocked);

    p_blocked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> (dout_oe == 2'b00));
endmodule

bind sram_bytelane sram_bytelane_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .lb_n    (lb_n),
    .ub_n    (ub_n),
    .dout_oe (dout_oe),
    .arm     (mode_q.sleep_arm),
    .asleep  (asleep),
    .blocked (blocked)
);

// File: tb/test_sram_bytelane.sv
module test_sram_bytelane;
    localparam int AW   = 10;
    localparam int WAKE = 4;

    typedef struct packed {
        logic        cs_n, we_n, oe_n, lb_n, ub_n;
        logic [9:0]  addr;
        logic [15:0] din;
        logic [1:0]  eoe;
        logic [15:0] edat;
    } vec_t;

    localparam int NV = 16;
    // R1 writes, R2 lane reads, R3 high-impedance cases, R4 unwritten bytes
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd5,    16'h0000, 2'b11, 16'hFFFF},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd5,    16'hA1B2, 2'b00, 16'h0000},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd5,    16'h0000, 2'b11, 16'hA1B2},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 10'd5,    16'hFF33, 2'b00, 16'h0000},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd5,    16'h0000, 2'b11, 16'hA133},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'd5,    16'h44EE, 2'b00, 16'h0000},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd5,    16'h0000, 2'b11, 16'h4433},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd5,    16'h0000, 2'b01, 16'h0033},
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10'd5,    16'h0000, 2'b10, 16'h4400},
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'd5,    16'h0000, 2'b00, 16'h0000},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd5,    16'h0000, 2'b00, 16'h0000},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'd5,    16'h0000, 2'b00, 16'h0000},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd9,    16'h77C5, 2'b00, 16'h0000},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd9,    16'h0000, 2'b11, 16'hFFC5},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd1023, 16'h5AA5, 2'b00, 16'h0000},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd1023, 16'h0000, 2'b11, 16'h5AA5}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   din = '0;
    logic [15:0]   dout;
    logic [1:0]    dout_oe;
    logic          sleep_i = 1'b0;
    logic          mode_ld = 1'b0;
    logic [2:0]    mode_din = '0;
    int            n_cmp = 0;
    int            n_bad = 0;

    always #10 clk = ~clk;

    sram_bytelane #(.AW(AW), .WAKE_CYC(WAKE)) i_sram_bytelane (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .din(din), .dout(dout),
        .dout_oe(dout_oe), .sleep_i(sleep_i), .mode_ld(mode_ld), .mode_din(mode_din)
    );

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic chk(string tag, logic [1:0] eoe, logic [15:0] edat);
        logic [15:0] m;
        m = {{8{eoe[1]}}, {8{eoe[0]}}};
        n_cmp++;
        if (dout_oe !== eoe || (dout & m) !== (edat & m)) begin
            n_bad++;
            $display("FAIL %s: oe=%b dout=%h expected oe=%b dout=%h", tag, dout_oe, dout & m, eoe, edat & m);
        end
    endtask

    // sets the controls at a falling edge, then waits for the result at the next falling edge
    task automatic op(logic c, logic w, logic o, logic l, logic u, logic [AW-1:0] a, logic [15:0] d);
        cs_n = c; we_n = w; oe_n = o; lb_n = l; ub_n = u; addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [15:0] d);
        op(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, d);
    endtask

    task automatic rd(logic [AW-1:0] a);
        op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a, 16'h0);
    endtask

    task automatic idle();
        op(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, 16'h0);
    endtask

    task automatic load_mode(logic [2:0] v);
        mode_ld = 1'b1; mode_din = v;
        idle();
        mode_ld = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R3 drive enable held low in reset", 2'b00, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 drive enable low after reset", 2'b00, 16'h0);

        for (int k = 0; k < NV; k++) begin
            op(VEC[k].cs_n, VEC[k].we_n, VEC[k].oe_n, VEC[k].lb_n, VEC[k].ub_n, VEC[k].addr, VEC[k].din);
            chk($sformatf("R1/R2/R3/R4 vector %0d", k), VEC[k].eoe, VEC[k].edat);
        end

        // R6: sleep pin while not armed changes nothing
        wr(10'd20, 16'h1234);
        sleep_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            rd(10'd20);
            chk("R6 sleep pin ignored when unarmed", 2'b11, 16'h1234);
        end
        sleep_i = 1'b0;

        // R5/R7: arm, sleep, accesses ignored and contents lost
        load_mode(3'b001);
        sleep_i = 1'b1;
        idle();
        for (int k = 0; k < 3; k++) begin
            rd(10'd20);
            chk("R7 read ignored while asleep", 2'b00, 16'h0);
            wr(10'd30, 16'hCAFE);
        end
        // R8: release, count blocked edges
        sleep_i = 1'b0;
        for (int k = 0; k <= WAKE; k++) begin
            rd(10'd20);
            chk($sformatf("R8 access blocked after wake, edge %0d", k), 2'b00, 16'h0);
        end
        rd(10'd20);
        chk("R8 first open read; R7 contents lost", 2'b11, 16'hFFFF);
        rd(10'd30);
        chk("R7 write during sleep not kept", 2'b11, 16'hFFFF);

        // R9 half region, deselect by chip select
        load_mode(3'b010);
        wr(10'd100, 16'h1111);
        wr(10'd511, 16'h3333);
        wr(10'd700, 16'h2222);
        idle();
        rd(10'd100);
        chk("R9 half keeps low address", 2'b11, 16'h1111);
        rd(10'd511);
        chk("R9 half keeps last retained word", 2'b11, 16'h3333);
        rd(10'd700);
        chk("R9 half loses upper address", 2'b11, 16'hFFFF);

        // R5/R9 eighth region, deselect by both lane enables high
        load_mode(3'b110);
        wr(10'd127, 16'h4444);
        wr(10'd128, 16'h5555);
        op(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd0, 16'h0);
        rd(10'd127);
        chk("R9 eighth keeps 127", 2'b11, 16'h4444);
        rd(10'd128);
        chk("R9 eighth loses 128", 2'b11, 16'hFFFF);

        // R9 full region keeps everything across deselect
        load_mode(3'b000);
        wr(10'd900, 16'h6789);
        idle();
        idle();
        rd(10'd900);
        chk("R9 full region keeps top address", 2'b11, 16'h6789);

        idle();
        report();
        $finish;
    end
endmodule